// File: doc/BRIEF.md
# Receive Fill Watermark and Request-to-Send Flow Control

This block sits beside a receive FIFO of a serial port and turns its fill level into three status signals and one line-control output. A programmable watermark produces a receive trigger and a one-cycle event pulse, which an interrupt controller can take. A second programmable level, the flow-delay threshold, produces a status-only trigger. When hardware flow control is on, that trigger also drives the request-to-send output with hysteresis, so the remote transmitter stops before the FIFO overflows.

The request-to-send output is active high: 1 means the far end may send. Hardware flow control deasserts it as soon as the fill reaches the flow-delay level. It asserts it again only once the fill has dropped at least four entries below that level. Between those two points it keeps its previous value. With flow control off, the output copies a software control bit. A flow-delay level below four turns flow-delay triggering off. A watermark of zero turns the receive trigger off. Every output is registered and changes one clock after the inputs that cause it.

Top module: `rxfill_flow_ctrl`

## Requirements
- R1: With `rx_thresh` equal to 0, `rx_trig` and `rx_evt` stay 0 whatever the fill level.
- R2: With `rx_thresh` nonzero, `rx_trig` one clock later equals (`fill_level` >= `rx_thresh`).
- R3: `rx_evt` is 1 for exactly the clock in which `rx_trig` goes from 0 to 1, and is 0 otherwise.
- R4: With `fd_thresh` >= 4, `flow_trig` one clock later equals (`fill_level` >= `fd_thresh`). It has no effect on `rx_trig` or `rx_evt`.
- R5: With `fd_thresh` < 4, `flow_trig` stays 0. With `hw_flow` = 1, `rts` is 1 one clock later.
- R6: With `hw_flow` = 1 and `fd_thresh` >= 4, a fill at or above `fd_thresh` makes `rts` 0 one clock later.
- R7: With `hw_flow` = 1 and `fd_thresh` >= 4, a fill at or below `fd_thresh` - 4 makes `rts` 1 one clock later. A fill strictly between those two points holds `rts` at its previous value.
- R8: With `hw_flow` = 0, `rts` one clock later equals `rts_manual`.
- R9: While `rst_n` is 0 at a clock edge, all outputs go to 0, so `rts` starts deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_level | input | 7 | Current receive FIFO occupancy, 0 to 64 |
| rx_thresh | input | 6 | Receive watermark, 0 disables |
| fd_thresh | input | 6 | Flow-delay level, values below 4 disable |
| hw_flow | input | 1 | 1 selects hardware flow control of `rts` |
| rts_manual | input | 1 | Software value of `rts` when `hw_flow` is 0 |
| rx_trig | output | 1 | Fill at or above the receive watermark |
| rx_evt | output | 1 | One-cycle pulse when `rx_trig` rises |
| flow_trig | output | 1 | Fill at or above the flow-delay level, status only |
| rts | output | 1 | Request-to-send, 1 means the peer may transmit |

## Verification
The bench steps through every flow-delay level with the fill ramping from 0 to 64 and back. This covers the exact trip point, where an off-by-one comparator would drop `rts` one entry late. It also covers the release point four below, where a design without hysteresis would re-assert `rts` too early. Levels 0 to 3 are included: a design that ignored the disable rule would drop `rts` or raise `flow_trig` there. Zero and nonzero watermarks run alongside, so a level-sensitive event or a live zero watermark shows up as stray `rx_evt` pulses. Switching modes inside the hold band checks that hardware mode keeps the value software last left, instead of forcing one.

// File: rtl/rxfill_pkg.sv
// Package: shared types for the receive-fill flow control block.
// Assumes: nothing beyond IEEE 1800-2017.
package rxfill_pkg;

    // Decision of the hysteresis stage for one clock.
    typedef enum logic [1:0] {
        RTS_HOLD = 2'd0,
        RTS_SET  = 2'd1,
        RTS_CLR  = 2'd2,
        RTS_SW   = 2'd3
    } rts_act_e;

endpackage

// File: rtl/rxfill_thr_cmp.sv
// Threshold comparator: reports whether a threshold is enabled (value at
// or above MIN_ON) and whether the fill level has reached it.
// Assumes: the level and the threshold are unsigned; THR_W < LVL_W.
module rxfill_thr_cmp #(
    parameter int LVL_W  = 7,
    parameter int THR_W  = 6,
    parameter int MIN_ON = 1
) (
    input  logic [LVL_W-1:0] level,
    input  logic [THR_W-1:0] thr,
    output logic             enabled,
    output logic             hit
);
    localparam int EXT = LVL_W - THR_W;

    logic [LVL_W-1:0] thr_ext;

    // Widen the threshold to level width and compare.
    always_comb begin
        thr_ext = {{EXT{1'b0}}, thr};
        enabled = (thr_ext >= LVL_W'(MIN_ON));
        hit     = enabled && (level >= thr_ext);
    end
endmodule

// File: rtl/rxfill_rts_hyst.sv
// Request-to-send stage: in hardware mode clears at the trip point and
// sets again once the level is HYST entries below it, holding in between.
// In software mode copies the manual bit. Output is a register.
// Assumes: fd_hit and fd_en come from the same cycle's level and threshold.
module rxfill_rts_hyst
    import rxfill_pkg::*;
#(
    parameter int LVL_W = 7,
    parameter int THR_W = 6,
    parameter int HYST  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_flow,
    input  logic             manual,
    input  logic [LVL_W-1:0] level,
    input  logic [THR_W-1:0] thr,
    input  logic             fd_en,
    input  logic             fd_hit,
    output logic             rts_q
);
    localparam int SUM_W = LVL_W + 1;

    rts_act_e         act;
    logic [SUM_W-1:0] lvl_plus;
    logic [SUM_W-1:0] thr_wide;
    logic             release_ok;

    // Work out the release point: level + HYST <= threshold.
    always_comb begin
        lvl_plus   = SUM_W'(level) + SUM_W'(HYST);
        thr_wide   = SUM_W'(thr);
        release_ok = (lvl_plus <= thr_wide);
    end

    // Pick this cycle's action from the mode and the thresholds.
    always_comb begin
        if (!hw_flow)        act = RTS_SW;
        else if (!fd_en)     act = RTS_SET;
        else if (fd_hit)     act = RTS_CLR;
        else if (release_ok) act = RTS_SET;
        else                 act = RTS_HOLD;
    end

    // Register the request-to-send line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rts_q <= 1'b0;
        end else begin
            case (act)
                RTS_SW:  rts_q <= manual;
                RTS_SET: rts_q <= 1'b1;
                RTS_CLR: rts_q <= 1'b0;
                default: rts_q <= rts_q;
            endcase
        end
    end
endmodule

// File: rtl/rxfill_flow_ctrl.sv
// Top: receive-fill watermark trigger with event pulse, flow-delay status
// trigger, and request-to-send control with hysteresis.
// Assumes: fill_level never exceeds 64; all inputs synchronous to clk.
module rxfill_flow_ctrl #(
    parameter int LVL_W  = 7,
    parameter int THR_W  = 6,
    parameter int HYST   = 4,
    parameter int FD_MIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] fill_level,
    input  logic [THR_W-1:0] rx_thresh,
    input  logic [THR_W-1:0] fd_thresh,
    input  logic             hw_flow,
    input  logic             rts_manual,
    output logic             rx_trig,
    output logic             rx_evt,
    output logic             flow_trig,
    output logic             rts
);
    logic rx_en, rx_hit;
    logic fd_en, fd_hit;

    rxfill_thr_cmp #(.LVL_W(LVL_W), .THR_W(THR_W), .MIN_ON(1)) u_rx_cmp (
        .level   (fill_level),
        .thr     (rx_thresh),
        .enabled (rx_en),
        .hit     (rx_hit)
    );

    rxfill_thr_cmp #(.LVL_W(LVL_W), .THR_W(THR_W), .MIN_ON(FD_MIN)) u_fd_cmp (
        .level   (fill_level),
        .thr     (fd_thresh),
        .enabled (fd_en),
        .hit     (fd_hit)
    );

    rxfill_rts_hyst #(.LVL_W(LVL_W), .THR_W(THR_W), .HYST(HYST)) u_rts (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_flow (hw_flow),
        .manual  (rts_manual),
        .level   (fill_level),
        .thr     (fd_thresh),
        .fd_en   (fd_en),
        .fd_hit  (fd_hit),
        .rts_q   (rts)
    );

    // Register both triggers and the rising-edge event of the watermark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_trig   <= 1'b0;
            rx_evt    <= 1'b0;
            flow_trig <= 1'b0;
        end else begin
            rx_trig   <= rx_en && rx_hit;
            rx_evt    <= rx_en && rx_hit && !rx_trig;
            flow_trig <= fd_hit;
        end
    end
endmodule

// File: rtl/rxfill_flow_ctrl_chk.sv
// Checker: temporal properties of the flow control block, bound to the top.
// Assumes: parameter defaults of the top (hysteresis of 4, minimum of 4).
module rxfill_flow_ctrl_chk #(
    parameter int LVL_W  = 7,
    parameter int THR_W  = 6,
    parameter int HYST   = 4,
    parameter int FD_MIN = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] fill_level,
    input logic [THR_W-1:0] rx_thresh,
    input logic [THR_W-1:0] fd_thresh,
    input logic             hw_flow,
    input logic             rts_manual,
    input logic             rx_trig,
    input logic             rx_evt,
    input logic             flow_trig,
    input logic             rts
);
    logic [LVL_W:0] lvl_w, fd_w;
    assign lvl_w = (LVL_W+1)'(fill_level);
    assign fd_w  = (LVL_W+1)'(fd_thresh);

    p_zero_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_thresh == '0) |=> (!rx_trig && !rx_evt));

    p_evt_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt |-> (rx_trig && !$past(rx_trig)));

    p_fd_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_flow && fd_w < (LVL_W+1)'(FD_MIN)) |=> (rts && !flow_trig));

    p_trip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_flow && fd_w >= (LVL_W+1)'(FD_MIN) && lvl_w >= fd_w)
        |=> (!rts && flow_trig));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_flow && fd_w >= (LVL_W+1)'(FD_MIN) && lvl_w < fd_w
         && lvl_w + (LVL_W+1)'(HYST) > fd_w) |=> $stable(rts));

    p_manual_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_flow |=> (rts == $past(rts_manual)));
endmodule

bind rxfill_flow_ctrl rxfill_flow_ctrl_chk #(
    .LVL_W(LVL_W), .THR_W(THR_W), .HYST(HYST), .FD_MIN(FD_MIN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_level (fill_level),
    .rx_thresh  (rx_thresh),
    .fd_thresh  (fd_thresh),
    .hw_flow    (hw_flow),
    .rts_manual (rts_manual),
    .rx_trig    (rx_trig),
    .rx_evt     (rx_evt),
    .flow_trig  (flow_trig),
    .rts        (rts)
);

// File: tb/test_rxfill_flow_ctrl.sv
module test_rxfill_flow_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] fill_level = '0;
    logic [5:0] rx_thresh = '0;
    logic [5:0] fd_thresh = '0;
    logic       hw_flow = 1'b0;
    logic       rts_manual = 1'b0;
    logic       rx_trig, rx_evt, flow_trig, rts;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // expected state
    bit e_trig = 0, e_evt = 0, e_flow = 0, e_rts = 0;

    always #4 clk = ~clk;

    rxfill_flow_ctrl i_rxfill_flow_ctrl (
        .clk(clk), .rst_n(rst_n), .fill_level(fill_level),
        .rx_thresh(rx_thresh), .fd_thresh(fd_thresh), .hw_flow(hw_flow),
        .rts_manual(rts_manual), .rx_trig(rx_trig), .rx_evt(rx_evt),
        .flow_trig(flow_trig), .rts(rts)
    );

    task automatic cmp(input string tag, input string what, input bit act, input bit exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b (lvl=%0d rx=%0d fd=%0d hw=%0b man=%0b)",
                     tag, what, act, exp, fill_level, rx_thresh, fd_thresh, hw_flow, rts_manual);
        end
    endtask

    // Drive one vector after a falling edge, model it, check at the next falling edge.
    task automatic apply(input int lvl, input int rxt, input int fdt, input bit hw, input bit man);
        bit rxhit, fdhit;
        fill_level = 7'(lvl);
        rx_thresh  = 6'(rxt);
        fd_thresh  = 6'(fdt);
        hw_flow    = hw;
        rts_manual = man;
        rxhit = (rxt != 0) && (lvl >= rxt);
        fdhit = (fdt >= 4) && (lvl >= fdt);
        if (!rst_n) begin
            e_trig = 0; e_evt = 0; e_flow = 0; e_rts = 0;
        end else begin
            e_evt  = rxhit && !e_trig;
            e_trig = rxhit;
            e_flow = fdhit;
            if (!hw)                e_rts = man;
            else if (fdt < 4)       e_rts = 1;
            else if (fdhit)         e_rts = 0;
            else if (lvl + 4 <= fdt) e_rts = 1;
        end
        @(negedge clk);
        if (!rst_n) begin
            cmp("R9", "rx_trig", rx_trig, 1'b0);
            cmp("R9", "rx_evt", rx_evt, 1'b0);
            cmp("R9", "flow_trig", flow_trig, 1'b0);
            cmp("R9", "rts", rts, 1'b0);
        end else begin
            cmp(rxt == 0 ? "R1" : "R2", "rx_trig", rx_trig, e_trig);
            cmp("R3", "rx_evt", rx_evt, e_evt);
            cmp(fdt < 4 ? "R5" : "R4", "flow_trig", flow_trig, e_flow);
            cmp(!hw ? "R8" : (fdt < 4 ? "R5" : (fdhit ? "R6" : "R7")), "rts", rts, e_rts);
        end
    endtask

    initial begin
        @(negedge clk);
        // R9: reset state with inputs that would otherwise set outputs
        apply(64, 1, 4, 1'b0, 1'b1);
        apply(30, 5, 3, 1'b1, 1'b1);
        rst_n = 1'b1;
        // R4 R5 R6 R7 with R1 R2 R3: every flow level, ramp up then down
        for (int fd = 0; fd < 64; fd++) begin
            int rt;
            rt = (fd * 7) % 64;
            for (int l = 0; l <= 64; l++) apply(l, rt, fd, 1'b1, 1'b0);
            for (int l = 64; l >= 0; l--) apply(l, rt, fd, 1'b1, 1'b0);
        end
        // R7: oscillate inside the hold band and across both edges
        for (int k = 0; k < 6; k++) begin
            apply(21, 0, 20, 1'b1, 1'b0);
            apply(18, 0, 20, 1'b1, 1'b0);
            apply(17, 0, 20, 1'b1, 1'b0);
            apply(16, 0, 20, 1'b1, 1'b0);
            apply(19, 0, 20, 1'b1, 1'b0);
            apply(20, 0, 20, 1'b1, 1'b0);
        end
        // R8: software mode over all levels, manual bit toggling
        for (int l = 0; l <= 64; l++) apply(l, 10, 20, 1'b0, 1'(l % 3 == 0));
        // R7 R8: mode switches inside the hold band keep the software value
        apply(18, 10, 20, 1'b0, 1'b1);
        apply(18, 10, 20, 1'b1, 1'b0);
        apply(19, 10, 20, 1'b1, 1'b0);
        apply(18, 10, 20, 1'b0, 1'b0);
        apply(18, 10, 20, 1'b1, 1'b1);
        apply(17, 10, 20, 1'b1, 1'b1);
        // R3: watermark raised then lowered while fill is constant
        apply(30, 40, 0, 1'b0, 1'b0);
        apply(30, 30, 0, 1'b0, 1'b0);
        apply(30, 30, 0, 1'b0, 1'b0);
        apply(30, 31, 0, 1'b0, 1'b0);
        apply(30, 29, 0, 1'b0, 1'b0);
        apply(30, 0, 0, 1'b0, 1'b0);
        apply(30, 1, 0, 1'b0, 1'b0);
        // R9: reset again mid-run
        rst_n = 1'b0;
        apply(64, 1, 10, 1'b1, 1'b1);
        rst_n = 1'b1;
        apply(5, 1, 10, 1'b1, 1'b1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule